// File: doc/BRIEF.md
# Dual-Channel UART Sleep Controller

This block decides when a two-channel UART may stop its shared crystal oscillator, and when it must start it again. It watches both channels: the interrupt-pending flags, the sleep-enable bits, the modem-status delta bits, the receive line levels and the four modem input levels of each channel. When every channel is quiet for a qualifying run of cycles, it drops the oscillator enable and reports sleep.

The block runs on a free-running, always-on clock. This lets edge detection on the serial and modem inputs keep working while the main oscillator is stopped. A wake event starts a modelled oscillator warm-up: a fixed count of cycles passes before the clock is reported ready again.

When a strap input is high during sleep, the block also isolates the host bus. In that state only line activity can wake the device; a host write to a transmitter cannot. A modem-triggered wake leaves a per-channel flag set, and that flag blocks sleep until the host reads the modem status of that channel.

Top module: `uart_sleep_ctl`

## Requirements
- R1: While `rst` is high, the outputs are `osc_en`=1, `clk_ready`=1, `asleep`=0 and `bus_iso`=0.
- R2: Sleep is entered when all of these hold at IDLE_CYC (default 4) consecutive rising edges: both `sleep_en` bits are 1, `irq_pend` is 0, all of `msr_delta` is 0, both `rx_in` bits are 1, and no modem-pending flag is set. `asleep` rises at the IDLE_CYC-th such edge. If any single condition is false, the device does not sleep.
- R3: `osc_en` is 0 exactly while `asleep` is 1.
- R4: While asleep, a falling edge on either `rx_in` bit wakes the device. A falling edge means the bit was 1 at the previous rising edge and is 0 at this one. `asleep` falls and `osc_en` rises at that same edge.
- R5: Any change of a bit in `modem_in` wakes a sleeping device. Channel c owns bits [4c+3:4c]. The change also sets channel c's modem-pending flag. While that flag is set, sleep cannot be re-entered. A one-cycle `msr_read[c]` pulse clears the flag at that edge, and sleep can then follow IDLE_CYC edges later.
- R6: A `tx_load` pulse wakes a sleeping device when `bus_iso` is 0. The pulse is ignored while `bus_iso` is 1.
- R7: Clearing either `sleep_en` bit while asleep wakes the device at the next edge.
- R8: `clk_ready` falls at the wake edge and rises STARTUP_CYC (default 8) edges later. `osc_en` stays 1 throughout.
- R9: `bus_iso` is 1 only while asleep with `ps_strap` high, and it follows `ps_strap` one edge later. Driving `ps_strap` low while asleep drops `bus_iso` but keeps the device asleep.
- R10: After a wake, sleep is re-entered automatically once warm-up has ended and the entry conditions have held again for IDLE_CYC edges. Warm-up cycles do not count toward the IDLE_CYC run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pend | input | NCH | Interrupt pending, one bit per channel |
| sleep_en | input | NCH | Sleep enable, one bit per channel |
| msr_delta | input | 4*NCH | Modem-status delta bits, four per channel |
| rx_in | input | NCH | Receive line levels |
| modem_in | input | 4*NCH | Modem input levels, four per channel |
| tx_load | input | NCH | Transmit-load strobe per channel |
| msr_read | input | NCH | Modem-status read strobe per channel |
| ps_strap | input | 1 | Power-save strap |
| osc_en | output | 1 | Oscillator enable |
| clk_ready | output | 1 | Oscillator warmed up and usable |
| asleep | output | 1 | Sleep status |
| bus_iso | output | 1 | Host bus isolation |

## Verification
The bench makes each entry condition false in turn and confirms that the device stays awake. A design that ANDs too few terms would fall asleep with a pending interrupt or a low line. Each wake source is exercised both with and without bus isolation. A design that lets transmit loads through in power-save would wake when it should not. The bench then holds re-entry until the modem-status read arrives. A design that forgets the modem-pending flag would drop back to sleep with a status change still unread. Exact edge counts on entry and on warm-up catch off-by-one counters, and warm-up cycles that count toward the idle run.

// File: rtl/sleep_ctl_pkg.sv
package sleep_ctl_pkg;
  typedef enum logic [1:0] {
    PW_RUN   = 2'd0,
    PW_SLEEP = 2'd1,
    PW_WARM  = 2'd2
  } pw_state_t;

  localparam int MDM_BITS = 4;
endpackage

// File: rtl/slp_wake_detect.sv
module slp_wake_detect
  import sleep_ctl_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCH-1:0]          rx_in,
  input  logic [NCH*MDM_BITS-1:0] modem_in,
  input  logic [NCH-1:0]          tx_load,
  input  logic [NCH-1:0]          msr_read,
  input  logic [NCH-1:0]          sleep_en,
  input  logic                    iso,
  output logic                    wake,
  output logic [NCH-1:0]          mdm_pend
);
  logic [NCH-1:0]          rx_q;
  logic [NCH*MDM_BITS-1:0] mdm_q;
  logic [NCH-1:0]          rx_fall;
  logic [NCH-1:0]          mdm_chg;

  // Per-channel edge detectors on the always-on clock
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    assign rx_fall[ch] = rx_q[ch] & ~rx_in[ch];
    assign mdm_chg[ch] = |(mdm_q[ch*MDM_BITS +: MDM_BITS] ^
                           modem_in[ch*MDM_BITS +: MDM_BITS]);

    // R5: a pending modem flag persists until its channel is read
    p_pend_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (mdm_pend[ch] && !msr_read[ch]) |=> mdm_pend[ch]);
  end

  // Host-side transmit loads are blocked while the bus is isolated
  assign wake = (|rx_fall) | (|mdm_chg) | ((|tx_load) & ~iso) | ~(&sleep_en);

  always_ff @(posedge clk) begin
    rx_q  <= rx_in;
    mdm_q <= modem_in;
    if (rst) begin
      mdm_pend <= '0;
    end else begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (mdm_chg[ch])       mdm_pend[ch] <= 1'b1;
        else if (msr_read[ch]) mdm_pend[ch] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/slp_entry_qual.sv
module slp_entry_qual
  import sleep_ctl_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int IDLE_CYC = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run,
  input  logic [NCH-1:0]          irq_pend,
  input  logic [NCH-1:0]          sleep_en,
  input  logic [NCH*MDM_BITS-1:0] msr_delta,
  input  logic [NCH-1:0]          rx_in,
  input  logic [NCH-1:0]          mdm_pend,
  output logic                    go_sleep
);
  localparam int QW = $clog2(IDLE_CYC + 1);
  localparam logic [QW-1:0] QLAST = QW'(IDLE_CYC - 1);

  logic [QW-1:0] qcnt;
  logic          quiet;

  assign quiet = (&sleep_en) && !(|irq_pend) && !(|msr_delta) &&
                 (&rx_in) && !(|mdm_pend);
  assign go_sleep = run && quiet && (qcnt == QLAST);

  always_ff @(posedge clk) begin
    if (rst || !run || !quiet) qcnt <= '0;
    else if (qcnt != QLAST)    qcnt <= qcnt + QW'(1);
  end

  // R2: the quiet-run counter never passes its terminal value
  p_qcnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    qcnt <= QLAST);
endmodule

// File: rtl/slp_power_fsm.sv
module slp_power_fsm
  import sleep_ctl_pkg::*;
#(
  parameter int STARTUP_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic go_sleep,
  input  logic wake,
  input  logic ps_strap,
  output logic run,
  output logic osc_en,
  output logic clk_ready,
  output logic asleep,
  output logic bus_iso
);
  localparam int WW = $clog2(STARTUP_CYC + 1);
  localparam logic [WW-1:0] WLAST = WW'(STARTUP_CYC - 1);

  pw_state_t     state, nxt;
  logic [WW-1:0] wcnt;

  always_comb begin
    nxt = state;
    case (state)
      PW_RUN:   if (go_sleep)      nxt = PW_SLEEP;
      PW_SLEEP: if (wake)          nxt = PW_WARM;
      PW_WARM:  if (wcnt == WLAST) nxt = PW_RUN;
      default:                     nxt = PW_RUN;
    endcase
  end

  assign run = (state == PW_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PW_RUN;
      wcnt      <= '0;
      osc_en    <= 1'b1;
      clk_ready <= 1'b1;
      asleep    <= 1'b0;
      bus_iso   <= 1'b0;
    end else begin
      state     <= nxt;
      wcnt      <= (state == PW_WARM && nxt == PW_WARM) ? wcnt + WW'(1) : '0;
      osc_en    <= (nxt != PW_SLEEP);
      clk_ready <= (nxt == PW_RUN);
      asleep    <= (nxt == PW_SLEEP);
      bus_iso   <= (nxt == PW_SLEEP) && ps_strap;
    end
  end

  p_osc_off_r3: assert property (@(posedge clk) disable iff (rst)
    asleep |-> !osc_en);
  p_iso_asleep_r9: assert property (@(posedge clk) disable iff (rst)
    bus_iso |-> asleep);
  p_ready_osc_r8: assert property (@(posedge clk) disable iff (rst)
    clk_ready |-> osc_en);
  p_wake_exit_r4: assert property (@(posedge clk) disable iff (rst)
    (asleep && wake) |=> (!asleep && !clk_ready));
endmodule

// File: rtl/uart_sleep_ctl.sv
module uart_sleep_ctl
  import sleep_ctl_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int IDLE_CYC    = 4,
  parameter int STARTUP_CYC = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCH-1:0]          irq_pend,
  input  logic [NCH-1:0]          sleep_en,
  input  logic [NCH*MDM_BITS-1:0] msr_delta,
  input  logic [NCH-1:0]          rx_in,
  input  logic [NCH*MDM_BITS-1:0] modem_in,
  input  logic [NCH-1:0]          tx_load,
  input  logic [NCH-1:0]          msr_read,
  input  logic                    ps_strap,
  output logic                    osc_en,
  output logic                    clk_ready,
  output logic                    asleep,
  output logic                    bus_iso
);
  logic           wake;
  logic           go_sleep;
  logic           run;
  logic [NCH-1:0] mdm_pend;

  slp_wake_detect #(.NCH(NCH)) u_wake (
    .clk      (clk),
    .rst      (rst),
    .rx_in    (rx_in),
    .modem_in (modem_in),
    .tx_load  (tx_load),
    .msr_read (msr_read),
    .sleep_en (sleep_en),
    .iso      (bus_iso),
    .wake     (wake),
    .mdm_pend (mdm_pend)
  );

  slp_entry_qual #(.NCH(NCH), .IDLE_CYC(IDLE_CYC)) u_qual (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .irq_pend  (irq_pend),
    .sleep_en  (sleep_en),
    .msr_delta (msr_delta),
    .rx_in     (rx_in),
    .mdm_pend  (mdm_pend),
    .go_sleep  (go_sleep)
  );

  slp_power_fsm #(.STARTUP_CYC(STARTUP_CYC)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .go_sleep  (go_sleep),
    .wake      (wake),
    .ps_strap  (ps_strap),
    .run       (run),
    .osc_en    (osc_en),
    .clk_ready (clk_ready),
    .asleep    (asleep),
    .bus_iso   (bus_iso)
  );

  // R2: no sleep is entered over a pending interrupt or a modem-status delta
  p_no_irq_entry_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(asleep) |-> ($past(irq_pend) == '0 && $past(msr_delta) == '0));
  // R5: no sleep is entered while a modem change is still unread
  p_mdm_entry_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(asleep) |-> ($past(mdm_pend) == '0));
endmodule

// File: tb/test_uart_sleep_ctl.sv
module test_uart_sleep_ctl;
  localparam int NCH     = 2;
  localparam int IDLE    = 4;
  localparam int STARTUP = 8;
  // {exp_sleep, sleep_en[1:0], irq_pend[1:0], rx_in[1:0], delta_bit}
  localparam logic [7:0] VEC [8] = '{8'hE6, 8'h26, 8'h46, 8'h6E,
                                     8'h76, 8'h64, 8'h62, 8'h67};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0]   irq_pend = '0, sleep_en = '1, rx_in = '1;
  logic [NCH-1:0]   tx_load = '0, msr_read = '0;
  logic [4*NCH-1:0] msr_delta = '0, modem_in = '0;
  logic ps_strap = 1'b0;
  logic osc_en, clk_ready, asleep, bus_iso;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  uart_sleep_ctl #(.NCH(NCH), .IDLE_CYC(IDLE), .STARTUP_CYC(STARTUP)) i_uart_sleep_ctl (
    .clk(clk), .rst(rst), .irq_pend(irq_pend), .sleep_en(sleep_en),
    .msr_delta(msr_delta), .rx_in(rx_in), .modem_in(modem_in),
    .tx_load(tx_load), .msr_read(msr_read), .ps_strap(ps_strap),
    .osc_en(osc_en), .clk_ready(clk_ready), .asleep(asleep), .bus_iso(bus_iso));

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic set_quiet();
    sleep_en = '1; irq_pend = '0; msr_delta = '0; rx_in = '1;
    tx_load = '0; msr_read = '0;
  endtask

  task automatic enter_sleep(string tag);
    set_quiet();
    tick(STARTUP + IDLE + 1);
    chk(tag, asleep, 1'b1);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1;
    // R1: reset values
    rst = 1'b1; set_quiet(); tick(2);
    chk("R1 osc_en", osc_en, 1'b1);
    chk("R1 clk_ready", clk_ready, 1'b1);
    chk("R1 asleep", asleep, 1'b0);
    chk("R1 bus_iso", bus_iso, 1'b0);

    // R2: each entry condition false in turn
    foreach (VEC[i]) begin
      sleep_en  = VEC[i][6:5];
      irq_pend  = VEC[i][4:3];
      rx_in     = VEC[i][2:1];
      msr_delta = {1'b0, VEC[i][0], 6'b0};
      rst = 1'b1; tick(2); rst = 1'b0;
      tick(IDLE + 2);
      chk($sformatf("R2 vector %0d", i), asleep, VEC[i][7]);
    end

    // R2/R3: exact entry edge
    set_quiet(); rst = 1'b1; tick(2); rst = 1'b0;
    tick(IDLE - 1); chk("R2 early", asleep, 1'b0);
    tick(1);        chk("R2 entry", asleep, 1'b1);
    chk("R3 osc off", osc_en, 1'b0);

    // R4/R8/R10: receive start-bit wake, warm-up, re-entry
    rx_in[0] = 1'b0; tick(1);
    chk("R4 rx wake", asleep, 1'b0);
    chk("R3 osc on", osc_en, 1'b1);
    chk("R8 not ready", clk_ready, 1'b0);
    tick(STARTUP - 1); chk("R8 still warming", clk_ready, 1'b0);
    chk("R8 osc during warm", osc_en, 1'b1);
    tick(1); chk("R8 ready", clk_ready, 1'b1);
    rx_in[0] = 1'b1;
    tick(IDLE - 1); chk("R10 early", asleep, 1'b0);
    tick(1);        chk("R10 re-entry", asleep, 1'b1);

    // R5: modem wake and blocking until status read
    modem_in[5] = ~modem_in[5]; tick(1);
    chk("R5 modem wake", asleep, 1'b0);
    tick(STARTUP + IDLE + 2); chk("R5 blocked", asleep, 1'b0);
    msr_read = 2'b10; tick(1); msr_read = '0;
    chk("R5 read edge", asleep, 1'b0);
    tick(IDLE - 1); chk("R5 early", asleep, 1'b0);
    tick(1);        chk("R5 re-entry", asleep, 1'b1);

    // R6: transmit load wakes when not isolated
    tx_load = 2'b01; tick(1); tx_load = '0;
    chk("R6 tx wake", asleep, 1'b0);
    enter_sleep("R10 after tx");

    // R7: clearing a sleep enable wakes
    sleep_en[1] = 1'b0; tick(1);
    chk("R7 wake", asleep, 1'b0);
    enter_sleep("R7 resleep");

    // R9: power-save isolation
    ps_strap = 1'b1; tick(1);
    chk("R9 iso on", bus_iso, 1'b1);
    tx_load = 2'b10; tick(1); tx_load = '0;
    chk("R6 tx ignored", asleep, 1'b1);
    tick(3);
    chk("R6 still asleep", asleep, 1'b1);
    chk("R9 iso held", bus_iso, 1'b1);

    rx_in[1] = 1'b0; tick(1);
    chk("R4 ps rx wake", asleep, 1'b0);
    chk("R9 iso off awake", bus_iso, 1'b0);
    rx_in[1] = 1'b1;
    enter_sleep("R10 ps resleep");
    chk("R9 iso resleep", bus_iso, 1'b1);

    modem_in[0] = ~modem_in[0]; tick(1);
    chk("R5 ps modem wake", asleep, 1'b0);
    tick(STARTUP + IDLE + 2); chk("R5 ps blocked", asleep, 1'b0);
    msr_read = 2'b01; tick(1); msr_read = '0;
    enter_sleep("R5 ps resleep");
    chk("R9 iso after read", bus_iso, 1'b1);

    ps_strap = 1'b0; tick(1);
    chk("R9 strap low iso", bus_iso, 1'b0);
    chk("R9 strap low asleep", asleep, 1'b1);
    tx_load = 2'b01; tick(1); tx_load = '0;
    chk("R6 tx wake after strap low", asleep, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule